// File: doc/BRIEF.md
# Serial Receive Path with Byte Queue

This block takes an asynchronous serial line, finds the start of each character, recovers eight data bits and one stop bit using a 16x oversampling tick, and pushes each good byte into a 16-entry first-in first-out queue. A processor drains the queue through a read strobe and a data port that always presents the oldest stored byte. The character assembly register is private to the block; the processor only sees the queue and the status flags.

The oversampling tick is an enable supplied from outside (a fixed divisor elsewhere makes it). The serial input first crosses a two-stage synchronizer. A character whose stop bit reads low is counted as a framing fault and is never queued; after such a fault the receiver waits for the line to return high before it looks for the next start bit. When the queue is full, arriving bytes are thrown away, the stored bytes stay untouched and a sticky overrun flag is raised.

Top module: `uart_rx_fifo_top`

## Requirements
- R1: A falling edge on `rxd` only starts a character if the line is still low half a bit time later (8 ticks of `baud_tick`); a low pulse shorter than that queues nothing and leaves `rx_count` unchanged.
- R2: Data bits arrive least significant bit first; bit i of the queued byte is the level of the i-th data bit after the start bit, each sampled near its bit centre (16 ticks per bit).
- R3: A byte with a high stop bit is written into the queue with no processor action, raising `rx_count` by one; the queue accepts 16 bytes without any read.
- R4: While `rx_count` is 16, a newly received byte is discarded and the 16 stored bytes are read back unchanged and in arrival order.
- R5: Asserting `rd_en` while `rx_count` is 0 changes neither `rx_count` nor the read position: the next byte received is the next byte read.
- R6: A character whose stop bit samples low is not queued and sets `frame_err`.
- R7: `overrun` rises when a byte is dropped for lack of space, stays high until `ovr_clr` is pulsed, and a drop in the same cycle as a clear keeps it set.
- R8: `frame_err` stays high until `ferr_clr` is pulsed.
- R9: `rd_data` shows the oldest stored byte; each cycle with `rd_en` high and a non-empty queue removes exactly one byte; `rx_avail` is high exactly when `rx_count` is non-zero.
- R10: After reset `rx_count` is 0 and `rx_avail`, `overrun` and `frame_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rd_en | input | 1 | Pop strobe for the queue |
| rd_data | output | 8 | Oldest queued byte (undefined when empty) |
| rx_count | output | 5 | Number of stored bytes, 0 to 16 |
| rx_avail | output | 1 | High when at least one byte is stored |
| ovr_clr | input | 1 | Clears `overrun` |
| overrun | output | 1 | Sticky: a byte was dropped on a full queue |
| ferr_clr | input | 1 | Clears `frame_err` |
| frame_err | output | 1 | Sticky: a stop bit sampled low |

## Verification
Characters are sent with alternating, single-bit-high and single-top-bit patterns (0xA5, 0x01, 0x80) so that a reversed or shifted bit order gives a different byte. A short low glitch separates real start detection from edge-triggered starts, and a frame with a low stop bit separates stop checking from blind queuing. A run of seventeen distinct bytes without reads tells a dropping full queue from an overwriting one, and a pop on an empty queue followed by a fresh byte shows whether the read position moved.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HUNT
    } rx_state_e;

    typedef struct packed {
        logic              vld;
        logic              ferr;
        logic [BYTE_W-1:0] data;
    } rx_event_t;

    function automatic logic [7:0] ptr_step(input logic [7:0] p, input int depth);
        return (int'(p) == depth - 1) ? 8'd0 : p + 8'd1;
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rx,
    output rx_event_t ev
);
    localparam int CW   = $clog2(OVS);
    localparam int BW   = $clog2(BYTE_W);
    localparam int HALF = OVS / 2 - 1;

    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bidx;
    logic [BYTE_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_IDLE;
            cnt   <= '0;
            bidx  <= '0;
            shreg <= '0;
            ev    <= '0;
        end else begin
            ev.vld  <= 1'b0;
            ev.ferr <= 1'b0;
            if (tick) begin
                unique case (state)
                    RX_IDLE: begin
                        cnt <= '0;
                        if (!rx) state <= RX_START;
                    end
                    RX_START: begin
                        if (cnt == CW'(HALF)) begin
                            cnt  <= '0;
                            bidx <= '0;
                            state <= rx ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == CW'(OVS - 1)) begin
                            cnt   <= '0;
                            shreg <= {rx, shreg[BYTE_W-1:1]};
                            if (bidx == BW'(BYTE_W - 1)) state <= RX_STOP;
                            else                         bidx  <= bidx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == CW'(OVS - 1)) begin
                            cnt     <= '0;
                            ev.data <= shreg;
                            if (rx) begin
                                ev.vld <= 1'b1;
                                state  <= RX_IDLE;
                            end else begin
                                ev.ferr <= 1'b1;
                                state   <= RX_HUNT;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_HUNT: begin
                        if (rx) state <= RX_IDLE;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              pop,
    output logic [BYTE_W-1:0] rdata,
    output logic [CNT_W-1:0]  count,
    output logic              dropped
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wptr, rptr;
    logic              full, empty, do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dropped = push && full;
    assign rdata   = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= PW'(ptr_step(8'(wptr), DEPTH));
            if (do_pop)  rptr <= PW'(ptr_step(8'(rptr), DEPTH));
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_fifo_top.sv
module uart_rx_fifo_top
    import uart_rx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              rxd,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    output logic [CNT_W-1:0]  rx_count,
    output logic              rx_avail,
    input  logic              ovr_clr,
    output logic              overrun,
    input  logic              ferr_clr,
    output logic              frame_err
);
    logic      rx_s;
    rx_event_t ev;
    logic      ev_vld, ev_ferr, drop;

    uart_rx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .din(rxd), .dout(rx_s)
    );

    uart_rx_deframer #(.OVS(OVS)) u_deframer (
        .clk(clk), .rst(rst), .tick(baud_tick), .rx(rx_s), .ev(ev)
    );

    assign ev_vld  = ev.vld;
    assign ev_ferr = ev.ferr;

    uart_rx_queue #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_queue (
        .clk(clk), .rst(rst), .push(ev_vld), .wdata(ev.data),
        .pop(rd_en), .rdata(rd_data), .count(rx_count), .dropped(drop)
    );

    assign rx_avail = (rx_count != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            overrun   <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            overrun   <= drop    | (overrun   & ~ovr_clr);
            frame_err <= ev_ferr | (frame_err & ~ferr_clr);
        end
    end
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_en,
    input logic             ovr_clr,
    input logic             ferr_clr,
    input logic             push_req,
    input logic             ferr_req,
    input logic             overrun,
    input logic             frame_err,
    input logic [CNT_W-1:0] rx_count
);
    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        rx_count <= CNT_W'(DEPTH));

    a_r3_push_adds: assert property (@(posedge clk) disable iff (rst)
        push_req && rx_count < CNT_W'(DEPTH) && !rd_en |=> rx_count == $past(rx_count) + 1'b1);

    a_r4_full_drop: assert property (@(posedge clk) disable iff (rst)
        push_req && rx_count == CNT_W'(DEPTH) && !rd_en |=> overrun && rx_count == CNT_W'(DEPTH));

    a_r5_empty_read: assert property (@(posedge clk) disable iff (rst)
        rd_en && rx_count == '0 && !push_req |=> rx_count == '0);

    a_r6_no_push_on_ferr: assert property (@(posedge clk) disable iff (rst)
        ferr_req |-> !push_req);

    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun && !ovr_clr |=> overrun);

    a_r8_ferr_sticky: assert property (@(posedge clk) disable iff (rst)
        frame_err && !ferr_clr |=> frame_err);

    a_r9_pop_once: assert property (@(posedge clk) disable iff (rst)
        rd_en && rx_count != '0 && !push_req |=> rx_count == $past(rx_count) - 1'b1);
endmodule

bind uart_rx_fifo_top uart_rx_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .ovr_clr(ovr_clr), .ferr_clr(ferr_clr),
    .push_req(ev_vld), .ferr_req(ev_ferr), .overrun(overrun),
    .frame_err(frame_err), .rx_count(rx_count)
);

// File: tb/uart_rx_fifo_top_test.sv
module uart_rx_fifo_top_test;
    localparam int DIV     = 2;
    localparam int BIT_CLK = 16 * DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rd_en = 1'b0;
    logic       ovr_clr = 1'b0;
    logic       ferr_clr = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] rx_count;
    logic       rx_avail, overrun, frame_err;

    int checks = 0;
    int errors = 0;
    int tdiv   = 0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        tdiv      <= (tdiv == DIV - 1) ? 0 : tdiv + 1;
        baud_tick <= (tdiv == DIV - 1);
    end

    uart_rx_fifo_top uut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .rxd(rxd), .rd_en(rd_en),
        .rd_data(rd_data), .rx_count(rx_count), .rx_avail(rx_avail),
        .ovr_clr(ovr_clr), .overrun(overrun), .ferr_clr(ferr_clr), .frame_err(frame_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic stop_bit);
        rxd = 1'b0;
        repeat (BIT_CLK) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BIT_CLK) @(negedge clk);
        end
        rxd = stop_bit;
        repeat (BIT_CLK) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic pop_expect(input string req, input int exp);
        check(req, rd_data, exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 count", rx_count, 0);
        check("R10 avail", rx_avail, 0);
        check("R10 overrun", overrun, 0);
        check("R10 frame_err", frame_err, 0);
    endtask

    task automatic t_bit_order();
        send(8'hA5, 1'b1);
        send(8'h01, 1'b1);
        send(8'h80, 1'b1);
        check("R3 count after three", rx_count, 3);
        check("R9 avail", rx_avail, 1);
        pop_expect("R2 byte A5", 8'hA5);
        check("R9 one pop", rx_count, 2);
        pop_expect("R2 byte 01", 8'h01);
        pop_expect("R2 byte 80", 8'h80);
        check("R9 drained", rx_count, 0);
        check("R9 avail low", rx_avail, 0);
    endtask

    task automatic t_glitch();
        rxd = 1'b0;
        repeat (3 * DIV) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT_CLK) @(negedge clk);
        check("R1 glitch ignored", rx_count, 0);
        send(8'h3C, 1'b1);
        pop_expect("R1 real start after glitch", 8'h3C);
    endtask

    task automatic t_empty_read();
        rd_en = 1'b1;
        repeat (3) @(negedge clk);
        rd_en = 1'b0;
        check("R5 count stays 0", rx_count, 0);
        send(8'h5A, 1'b1);
        check("R5 one byte", rx_count, 1);
        pop_expect("R5 read position kept", 8'h5A);
    endtask

    task automatic t_frame();
        send(8'hC3, 1'b0);
        check("R6 not queued", rx_count, 0);
        check("R6 frame_err set", frame_err, 1);
        send(8'h11, 1'b1);
        check("R8 still set", frame_err, 1);
        ferr_clr = 1'b1;
        @(negedge clk);
        ferr_clr = 1'b0;
        @(negedge clk);
        check("R8 cleared", frame_err, 0);
        pop_expect("R6 next good byte", 8'h11);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 16; i++) send(8'(8'h40 + i), 1'b1);
        check("R3 sixteen stored", rx_count, 16);
        check("R7 no overrun yet", overrun, 0);
        send(8'hEE, 1'b1);
        check("R4 count held", rx_count, 16);
        check("R7 overrun set", overrun, 1);
        repeat (5) @(negedge clk);
        check("R7 sticky", overrun, 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        @(negedge clk);
        check("R7 cleared", overrun, 0);
        for (int i = 0; i < 16; i++) pop_expect("R4 stored data kept", 8'h40 + i);
        check("R4 drained", rx_count, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_bit_order();
        t_glitch();
        t_empty_read();
        t_frame();
        t_fill();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule